// File: doc/BRIEF.md
# Trace Unit Integration Test Pin Override Bank

This block sits at the pin boundary of a trace unit and lets test software prove the unit's wiring at chip integration. In normal operation every boundary output carries the value from the functional trace logic. Software can write 1 to bit 0 of a mode register. The bank then takes over the outputs, and each one is driven from a software-written register field.

The overridden outputs belong to two trace-bus masters, one for data and one for instructions. For each master they are the valid, flush-ready, byte-count and ID outputs, plus a sparse subset of its data bits. Two miscellaneous outputs are also overridden: an external-out bus and an "active" flag. Read-only registers return the live level of the handshake inputs of both masters, and of the debug-acknowledge, CPU-active and event inputs. Software can therefore check signals in both directions.

A two-state machine holds the mode. The states are FUNCTIONAL and INTEGRATION. The transition ENTER is a write of 1 to mode bit 0 while FUNCTIONAL. The transition LEAVE is a write of 0 to mode bit 0 while INTEGRATION. Any other mode write keeps the current state. Register access is a single 32-bit port. Writes take effect at the clock edge and reads are combinational while `reg_rd` is high.

Top module: `trace_itest_regs`

## Requirements
- R1: After synchronous active-low reset the state is FUNCTIONAL and all override fields are 0. Every overridden output equals its functional-path input.
- R2: The mode register is at offset 0xF00. Writing bit 0 = 1 performs ENTER and writing bit 0 = 0 performs LEAVE, both effective after the write's clock edge. A read returns the current mode in bit 0 and 0 in bits [31:1].
- R3: While FUNCTIONAL, a read of any offset other than 0xF00 returns 0. A write to an override register has no effect, which is visible after a later ENTER by readback and at the pins.
- R4: Offset 0xEDC: bits [11:8] drive `ext_out_o` and bit 5 drives `active_o`, starting the cycle after the write. Readback returns those bits in place.
- R5: Offset 0xEE4 holds a 7-bit ID. Bits [6:1] drive bits [6:1] of both `dat_id_o` and `ins_id_o`. Bit 0 drives `ins_id_o[0]`. `dat_id_o[0]` is 1 throughout INTEGRATION.
- R6: Offset 0xEE8: bit k of [8:0] drives `dat_data_o` at bit 0 for k=0 and at bit 8k-1 otherwise, which gives bits 0, 7, 15, …, 63. All other data bits are 0 in INTEGRATION.
- R7: Offset 0xEEC: bit k of [4:0] drives `ins_data_o` at bit 0 for k=0 and at bit 8k-1 otherwise, which gives bits 0, 7, 15, 23 and 31. All other bits are 0.
- R8: At offset 0xEF8, bits [10:8] drive `dat_bytes_o`, bit 1 drives `dat_flush_rdy_o` and bit 0 drives `dat_valid_o`. At offset 0xEFC, bits [9:8] drive `ins_bytes_o`, bit 1 drives `ins_flush_rdy_o` and bit 0 drives `ins_valid_o`.
- R9: The input registers return live pin levels in the same cycle as the read. Offset 0xEE0 returns {debug-ack in bit 5, CPU-active in bit 4, event in bits [3:0]}. Offsets 0xEF0 (data) and 0xEF4 (instruction) return flush-valid in bit 1 and ready in bit 0.
- R10: After LEAVE, all outputs follow the functional path again from the next cycle. Override values are kept and reappear at a later ENTER.
- R11: Reserved bits read as 0. An unmapped or misaligned offset reads 0, and a write to it changes no output and no register.
- R12: If a read and a write address the same register in one cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational while reg_rd is high |
| fn_dat_valid | input | 1 | Functional data-master valid |
| fn_dat_flush_rdy | input | 1 | Functional data-master flush-ready |
| fn_dat_bytes | input | 3 | Functional data-master byte count |
| fn_dat_data | input | DATA_W | Functional data-master data |
| fn_dat_id | input | 7 | Functional data-master ID |
| fn_ins_valid | input | 1 | Functional instruction-master valid |
| fn_ins_flush_rdy | input | 1 | Functional instruction-master flush-ready |
| fn_ins_bytes | input | 2 | Functional instruction-master byte count |
| fn_ins_data | input | INST_W | Functional instruction-master data |
| fn_ins_id | input | 7 | Functional instruction-master ID |
| fn_ext_out | input | 4 | Functional external-out bus |
| fn_active | input | 1 | Functional active flag |
| dat_valid_o | output | 1 | Data-master valid pin |
| dat_flush_rdy_o | output | 1 | Data-master flush-ready pin |
| dat_bytes_o | output | 3 | Data-master byte-count pins |
| dat_data_o | output | DATA_W | Data-master data pins |
| dat_id_o | output | 7 | Data-master ID pins |
| ins_valid_o | output | 1 | Instruction-master valid pin |
| ins_flush_rdy_o | output | 1 | Instruction-master flush-ready pin |
| ins_bytes_o | output | 2 | Instruction-master byte-count pins |
| ins_data_o | output | INST_W | Instruction-master data pins |
| ins_id_o | output | 7 | Instruction-master ID pins |
| ext_out_o | output | 4 | External-out pins |
| active_o | output | 1 | Active pin |
| dat_ready_i | input | 1 | Data-master ready pin |
| dat_flush_valid_i | input | 1 | Data-master flush-valid pin |
| ins_ready_i | input | 1 | Instruction-master ready pin |
| ins_flush_valid_i | input | 1 | Instruction-master flush-valid pin |
| dbg_ack_i | input | 1 | Debug-acknowledge pin |
| cpu_active_i | input | 1 | CPU-active pin |
| event_i | input | 4 | Event pins |

## Verification
The register read path and the override write path can act on the same register in one clock. The bench raises `reg_rd` and `reg_wr` together on 0xEDC while the register holds a known older value. It samples `reg_rdata` before the edge and expects the older value. After the edge it expects the new value both on a fresh read and on `ext_out_o`. A second collision happens at the mode boundary: the bench reads an override register in the same cycle that LEAVE is written, and expects the readback to reflect the INTEGRATION state that still holds.

// File: rtl/trace_itest_pkg.sv
package trace_itest_pkg;

    localparam int unsigned AW    = 12;
    localparam int unsigned ID_W  = 7;
    localparam int unsigned EXT_W = 4;
    localparam int unsigned DBY_W = 3;
    localparam int unsigned IBY_W = 2;

    localparam logic [AW-1:0] OFS_MISC_OUT = 12'hEDC;
    localparam logic [AW-1:0] OFS_MISC_IN  = 12'hEE0;
    localparam logic [AW-1:0] OFS_ID       = 12'hEE4;
    localparam logic [AW-1:0] OFS_DDATA    = 12'hEE8;
    localparam logic [AW-1:0] OFS_IDATA    = 12'hEEC;
    localparam logic [AW-1:0] OFS_DIN      = 12'hEF0;
    localparam logic [AW-1:0] OFS_IIN      = 12'hEF4;
    localparam logic [AW-1:0] OFS_DOUT     = 12'hEF8;
    localparam logic [AW-1:0] OFS_IOUT     = 12'hEFC;
    localparam logic [AW-1:0] OFS_MODE     = 12'hF00;

    typedef enum logic {
        ST_FUNC  = 1'b0,
        ST_INTEG = 1'b1
    } itest_state_e;

    typedef struct packed {
        logic [EXT_W-1:0] ext;
        logic             active;
        logic [ID_W-1:0]  id;
        logic [DBY_W-1:0] dbytes;
        logic             dflush;
        logic             dvalid;
        logic [IBY_W-1:0] ibytes;
        logic             iflush;
        logic             ivalid;
    } ovr_fields_t;

    // Bus bit driven by sparse override bit k: 0 for k=0, else 8k-1
    function automatic int unsigned sparse_pos(input int unsigned k);
        return (k == 0) ? 0 : (8 * k - 1);
    endfunction

endpackage

// File: rtl/itest_mode_fsm.sv
module itest_mode_fsm
    import trace_itest_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_wr,
    input  logic         mode_bit,
    output itest_state_e state_q
);

    itest_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FUNC;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FUNC:  if (mode_wr && mode_bit)  state_d = ST_INTEG;  // ENTER
            ST_INTEG: if (mode_wr && !mode_bit) state_d = ST_FUNC;   // LEAVE
        endcase
    end

endmodule

// File: rtl/itest_ovr_regs.sv
module itest_ovr_regs
    import trace_itest_pkg::*;
#(
    parameter int unsigned DS_N = 9,
    parameter int unsigned IS_N = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [11:0]       wdata,
    output ovr_fields_t       fields_q,
    output logic [DS_N-1:0]   dsparse_q,
    output logic [IS_N-1:0]   isparse_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields_q  <= '0;
            dsparse_q <= '0;
            isparse_q <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_MISC_OUT: begin
                    fields_q.ext    <= wdata[11:8];
                    fields_q.active <= wdata[5];
                end
                OFS_ID:    fields_q.id <= wdata[ID_W-1:0];
                OFS_DDATA: dsparse_q   <= wdata[DS_N-1:0];
                OFS_IDATA: isparse_q   <= wdata[IS_N-1:0];
                OFS_DOUT: begin
                    fields_q.dbytes <= wdata[8 +: DBY_W];
                    fields_q.dflush <= wdata[1];
                    fields_q.dvalid <= wdata[0];
                end
                OFS_IOUT: begin
                    fields_q.ibytes <= wdata[8 +: IBY_W];
                    fields_q.iflush <= wdata[1];
                    fields_q.ivalid <= wdata[0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/itest_pin_mux.sv
module itest_pin_mux
    import trace_itest_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned INST_W = 32,
    parameter int unsigned DS_N   = DATA_W / 8 + 1,
    parameter int unsigned IS_N   = INST_W / 8 + 1
) (
    input  logic              integ,
    input  ovr_fields_t       fields,
    input  logic [DS_N-1:0]   dsparse,
    input  logic [IS_N-1:0]   isparse,
    input  logic              fn_dat_valid,
    input  logic              fn_dat_flush_rdy,
    input  logic [DBY_W-1:0]  fn_dat_bytes,
    input  logic [DATA_W-1:0] fn_dat_data,
    input  logic [ID_W-1:0]   fn_dat_id,
    input  logic              fn_ins_valid,
    input  logic              fn_ins_flush_rdy,
    input  logic [IBY_W-1:0]  fn_ins_bytes,
    input  logic [INST_W-1:0] fn_ins_data,
    input  logic [ID_W-1:0]   fn_ins_id,
    input  logic [EXT_W-1:0]  fn_ext_out,
    input  logic              fn_active,
    output logic              dat_valid_o,
    output logic              dat_flush_rdy_o,
    output logic [DBY_W-1:0]  dat_bytes_o,
    output logic [DATA_W-1:0] dat_data_o,
    output logic [ID_W-1:0]   dat_id_o,
    output logic              ins_valid_o,
    output logic              ins_flush_rdy_o,
    output logic [IBY_W-1:0]  ins_bytes_o,
    output logic [INST_W-1:0] ins_data_o,
    output logic [ID_W-1:0]   ins_id_o,
    output logic [EXT_W-1:0]  ext_out_o,
    output logic              active_o
);

    logic [DATA_W-1:0] dspread;
    logic [INST_W-1:0] ispread;

    always_comb begin
        dspread = '0;
        for (int unsigned k = 0; k < DS_N; k++) dspread[sparse_pos(k)] = dsparse[k];
    end

    always_comb begin
        ispread = '0;
        for (int unsigned k = 0; k < IS_N; k++) ispread[sparse_pos(k)] = isparse[k];
    end

    always_comb begin
        if (integ) begin
            dat_valid_o     = fields.dvalid;
            dat_flush_rdy_o = fields.dflush;
            dat_bytes_o     = fields.dbytes;
            dat_data_o      = dspread;
            dat_id_o        = {fields.id[ID_W-1:1], 1'b1};
            ins_valid_o     = fields.ivalid;
            ins_flush_rdy_o = fields.iflush;
            ins_bytes_o     = fields.ibytes;
            ins_data_o      = ispread;
            ins_id_o        = fields.id;
            ext_out_o       = fields.ext;
            active_o        = fields.active;
        end else begin
            dat_valid_o     = fn_dat_valid;
            dat_flush_rdy_o = fn_dat_flush_rdy;
            dat_bytes_o     = fn_dat_bytes;
            dat_data_o      = fn_dat_data;
            dat_id_o        = fn_dat_id;
            ins_valid_o     = fn_ins_valid;
            ins_flush_rdy_o = fn_ins_flush_rdy;
            ins_bytes_o     = fn_ins_bytes;
            ins_data_o      = fn_ins_data;
            ins_id_o        = fn_ins_id;
            ext_out_o       = fn_ext_out;
            active_o        = fn_active;
        end
    end

endmodule

// File: rtl/itest_rd_mux.sv
module itest_rd_mux
    import trace_itest_pkg::*;
#(
    parameter int unsigned DS_N = 9,
    parameter int unsigned IS_N = 5
) (
    input  logic             rd,
    input  logic             integ,
    input  logic [AW-1:0]    addr,
    input  ovr_fields_t      fields,
    input  logic [DS_N-1:0]  dsparse,
    input  logic [IS_N-1:0]  isparse,
    input  logic             dat_ready_i,
    input  logic             dat_flush_valid_i,
    input  logic             ins_ready_i,
    input  logic             ins_flush_valid_i,
    input  logic             dbg_ack_i,
    input  logic             cpu_active_i,
    input  logic [EXT_W-1:0] event_i,
    output logic [31:0]      rdata
);

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == OFS_MODE) begin
                rdata[0] = integ;
            end else if (integ) begin
                case (addr)
                    OFS_MISC_OUT: begin
                        rdata[11:8] = fields.ext;
                        rdata[5]    = fields.active;
                    end
                    OFS_MISC_IN: begin
                        rdata[5]   = dbg_ack_i;
                        rdata[4]   = cpu_active_i;
                        rdata[3:0] = event_i;
                    end
                    OFS_ID:    rdata[ID_W-1:0] = fields.id;
                    OFS_DDATA: rdata[DS_N-1:0] = dsparse;
                    OFS_IDATA: rdata[IS_N-1:0] = isparse;
                    OFS_DIN:   rdata[1:0]      = {dat_flush_valid_i, dat_ready_i};
                    OFS_IIN:   rdata[1:0]      = {ins_flush_valid_i, ins_ready_i};
                    OFS_DOUT: begin
                        rdata[8 +: DBY_W] = fields.dbytes;
                        rdata[1:0]        = {fields.dflush, fields.dvalid};
                    end
                    OFS_IOUT: begin
                        rdata[8 +: IBY_W] = fields.ibytes;
                        rdata[1:0]        = {fields.iflush, fields.ivalid};
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/trace_itest_regs.sv
module trace_itest_regs
    import trace_itest_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned INST_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fn_dat_valid,
    input  logic              fn_dat_flush_rdy,
    input  logic [2:0]        fn_dat_bytes,
    input  logic [DATA_W-1:0] fn_dat_data,
    input  logic [6:0]        fn_dat_id,
    input  logic              fn_ins_valid,
    input  logic              fn_ins_flush_rdy,
    input  logic [1:0]        fn_ins_bytes,
    input  logic [INST_W-1:0] fn_ins_data,
    input  logic [6:0]        fn_ins_id,
    input  logic [3:0]        fn_ext_out,
    input  logic              fn_active,
    output logic              dat_valid_o,
    output logic              dat_flush_rdy_o,
    output logic [2:0]        dat_bytes_o,
    output logic [DATA_W-1:0] dat_data_o,
    output logic [6:0]        dat_id_o,
    output logic              ins_valid_o,
    output logic              ins_flush_rdy_o,
    output logic [1:0]        ins_bytes_o,
    output logic [INST_W-1:0] ins_data_o,
    output logic [6:0]        ins_id_o,
    output logic [3:0]        ext_out_o,
    output logic              active_o,
    input  logic              dat_ready_i,
    input  logic              dat_flush_valid_i,
    input  logic              ins_ready_i,
    input  logic              ins_flush_valid_i,
    input  logic              dbg_ack_i,
    input  logic              cpu_active_i,
    input  logic [3:0]        event_i
);

    localparam int unsigned DS_N = DATA_W / 8 + 1;
    localparam int unsigned IS_N = INST_W / 8 + 1;

    itest_state_e      state_q;
    logic              itest_on;
    logic              mode_wr;
    ovr_fields_t       fields_q;
    logic [DS_N-1:0]   dsparse_q;
    logic [IS_N-1:0]   isparse_q;
    logic              wdata_unused;

    assign itest_on     = (state_q == ST_INTEG);
    assign mode_wr      = reg_wr && (reg_addr == OFS_MODE);
    assign wdata_unused = ^reg_wdata[31:12];

    itest_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (mode_wr),
        .mode_bit (reg_wdata[0]),
        .state_q  (state_q)
    );

    itest_ovr_regs #(.DS_N(DS_N), .IS_N(IS_N)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr && itest_on),
        .addr      (reg_addr),
        .wdata     (reg_wdata[11:0]),
        .fields_q  (fields_q),
        .dsparse_q (dsparse_q),
        .isparse_q (isparse_q)
    );

    itest_pin_mux #(.DATA_W(DATA_W), .INST_W(INST_W), .DS_N(DS_N), .IS_N(IS_N)) u_mux (
        .integ            (itest_on),
        .fields           (fields_q),
        .dsparse          (dsparse_q),
        .isparse          (isparse_q),
        .fn_dat_valid     (fn_dat_valid),
        .fn_dat_flush_rdy (fn_dat_flush_rdy),
        .fn_dat_bytes     (fn_dat_bytes),
        .fn_dat_data      (fn_dat_data),
        .fn_dat_id        (fn_dat_id),
        .fn_ins_valid     (fn_ins_valid),
        .fn_ins_flush_rdy (fn_ins_flush_rdy),
        .fn_ins_bytes     (fn_ins_bytes),
        .fn_ins_data      (fn_ins_data),
        .fn_ins_id        (fn_ins_id),
        .fn_ext_out       (fn_ext_out),
        .fn_active        (fn_active),
        .dat_valid_o      (dat_valid_o),
        .dat_flush_rdy_o  (dat_flush_rdy_o),
        .dat_bytes_o      (dat_bytes_o),
        .dat_data_o       (dat_data_o),
        .dat_id_o         (dat_id_o),
        .ins_valid_o      (ins_valid_o),
        .ins_flush_rdy_o  (ins_flush_rdy_o),
        .ins_bytes_o      (ins_bytes_o),
        .ins_data_o       (ins_data_o),
        .ins_id_o         (ins_id_o),
        .ext_out_o        (ext_out_o),
        .active_o         (active_o)
    );

    itest_rd_mux #(.DS_N(DS_N), .IS_N(IS_N)) u_rd (
        .rd                (reg_rd),
        .integ             (itest_on),
        .addr              (reg_addr),
        .fields            (fields_q),
        .dsparse           (dsparse_q),
        .isparse           (isparse_q),
        .dat_ready_i       (dat_ready_i),
        .dat_flush_valid_i (dat_flush_valid_i),
        .ins_ready_i       (ins_ready_i),
        .ins_flush_valid_i (ins_flush_valid_i),
        .dbg_ack_i         (dbg_ack_i),
        .cpu_active_i      (cpu_active_i),
        .event_i           (event_i),
        .rdata             (reg_rdata)
    );

endmodule

// File: rtl/trace_itest_regs_chk.sv
module trace_itest_regs_chk
    import trace_itest_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned INST_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [11:0]       reg_addr,
    input logic              wbit0,
    input logic [31:0]       reg_rdata,
    input logic              itest_on,
    input logic [DATA_W-1:0] fn_dat_data,
    input logic [6:0]        fn_ins_id,
    input logic [3:0]        fn_ext_out,
    input logic [DATA_W-1:0] dat_data_o,
    input logic [6:0]        dat_id_o,
    input logic [6:0]        ins_id_o,
    input logic [3:0]        ext_out_o,
    input logic              dbg_ack_i,
    input logic              cpu_active_i,
    input logic [3:0]        event_i
);

    localparam int unsigned DS_N = DATA_W / 8 + 1;

    logic [DATA_W-1:0] sparse_mask;
    always_comb begin
        sparse_mask = '0;
        for (int unsigned k = 0; k < DS_N; k++) sparse_mask[sparse_pos(k)] = 1'b1;
    end

    AST_FUNC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !itest_on |-> (dat_data_o == fn_dat_data && ins_id_o == fn_ins_id && ext_out_o == fn_ext_out)); // R1
    AST_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_MODE && wbit0) |=> itest_on); // R2
    AST_RD_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!itest_on && reg_rd && reg_addr != OFS_MODE) |-> (reg_rdata == 32'h0)); // R3
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (itest_on && $past(itest_on) && !$past(reg_wr)) |-> $stable(ext_out_o)); // R4
    AST_DID_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        itest_on |-> dat_id_o[0]); // R5
    AST_ID_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        itest_on |-> (dat_id_o[6:1] == ins_id_o[6:1])); // R5
    AST_NONSPARSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        itest_on |-> ((dat_data_o & ~sparse_mask) == '0)); // R6
    AST_MISCIN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (itest_on && reg_rd && reg_addr == OFS_MISC_IN) |->
        (reg_rdata == {26'h0, dbg_ack_i, cpu_active_i, event_i})); // R9
    AST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_MODE && !wbit0) |=> (ext_out_o == fn_ext_out)); // R10

endmodule

bind trace_itest_regs trace_itest_regs_chk #(.DATA_W(DATA_W), .INST_W(INST_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .wbit0        (reg_wdata[0]),
    .reg_rdata    (reg_rdata),
    .itest_on     (itest_on),
    .fn_dat_data  (fn_dat_data),
    .fn_ins_id    (fn_ins_id),
    .fn_ext_out   (fn_ext_out),
    .dat_data_o   (dat_data_o),
    .dat_id_o     (dat_id_o),
    .ins_id_o     (ins_id_o),
    .ext_out_o    (ext_out_o),
    .dbg_ack_i    (dbg_ack_i),
    .cpu_active_i (cpu_active_i),
    .event_i      (event_i)
);

// File: tb/trace_itest_regs_bench.sv
module trace_itest_regs_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        fn_dat_valid = 1'b1, fn_dat_flush_rdy = 1'b0;
    logic [2:0]  fn_dat_bytes = 3'd6;
    logic [63:0] fn_dat_data = 64'hDEAD_BEEF_0123_4567;
    logic [6:0]  fn_dat_id = 7'h12;
    logic        fn_ins_valid = 1'b0, fn_ins_flush_rdy = 1'b1;
    logic [1:0]  fn_ins_bytes = 2'd1;
    logic [31:0] fn_ins_data = 32'hCAFE_F00D;
    logic [6:0]  fn_ins_id = 7'h34;
    logic [3:0]  fn_ext_out = 4'h9;
    logic        fn_active = 1'b1;
    logic        dat_valid_o, dat_flush_rdy_o, ins_valid_o, ins_flush_rdy_o, active_o;
    logic [2:0]  dat_bytes_o;
    logic [1:0]  ins_bytes_o;
    logic [63:0] dat_data_o;
    logic [31:0] ins_data_o;
    logic [6:0]  dat_id_o, ins_id_o;
    logic [3:0]  ext_out_o;
    logic        dat_ready_i = 1'b0, dat_flush_valid_i = 1'b0;
    logic        ins_ready_i = 1'b0, ins_flush_valid_i = 1'b0;
    logic        dbg_ack_i = 1'b0, cpu_active_i = 1'b0;
    logic [3:0]  event_i = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    trace_itest_regs u_trace_itest_regs (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    function automatic logic [63:0] spread(input logic [8:0] v, input int n);
        logic [63:0] r = '0;
        for (int k = 0; k < n; k++) r[(k == 0) ? 0 : 8 * k - 1] = v[k];
        return r;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 dat_data", dat_data_o, fn_dat_data);
        chk("R1 ins_id", {57'h0, ins_id_o}, {57'h0, fn_ins_id});
        chk("R1 misc", {59'h0, ext_out_o, active_o}, {59'h0, fn_ext_out, fn_active});
        chk("R1 dat ctl", {58'h0, dat_bytes_o, dat_flush_rdy_o, dat_valid_o},
            {58'h0, fn_dat_bytes, fn_dat_flush_rdy, fn_dat_valid});
        rd(12'hF00, d);
        chk("R2 mode after reset", {32'h0, d}, 64'h0);
    endtask

    task automatic t_off_access();
        logic [31:0] d;
        rd(12'hEDC, d);
        chk("R3 read while functional", {32'h0, d}, 64'h0);
        wr(12'hEDC, 32'h0000_0F20);
        chk("R3 pin untouched", {60'h0, ext_out_o}, {60'h0, fn_ext_out});
    endtask

    task automatic t_enter();
        logic [31:0] d;
        wr(12'hF00, 32'hFFFF_FFFF);
        rd(12'hF00, d);
        chk("R2 mode readback", {32'h0, d}, 64'h1);
        rd(12'hEDC, d);
        chk("R3 earlier write ignored", {32'h0, d}, 64'h0);
        chk("R3 ext pins zero", {59'h0, ext_out_o, active_o}, 64'h0);
        chk("R5 data id bit0 high", {57'h0, dat_id_o}, 64'h1);
    endtask

    task automatic t_misc();
        logic [31:0] d;
        wr(12'hEDC, 32'h0000_0A20);
        chk("R4 ext/active pins", {59'h0, ext_out_o, active_o}, {59'h0, 4'hA, 1'b1});
        wr(12'hEDC, 32'hFFFF_FFFF);
        rd(12'hEDC, d);
        chk("R11 reserved read zero", {32'h0, d}, 64'hF20);
        wr(12'hEDC, 32'h0000_0500);
        chk("R4 active low", {59'h0, ext_out_o, active_o}, {59'h0, 4'h5, 1'b0});
    endtask

    task automatic t_id();
        wr(12'hEE4, 32'h0000_0055);
        chk("R5 ins id", {57'h0, ins_id_o}, 64'h55);
        chk("R5 dat id", {57'h0, dat_id_o}, 64'h55);
        wr(12'hEE4, 32'h0000_002A);
        chk("R5 ins id bit0 low", {57'h0, ins_id_o}, 64'h2A);
        chk("R5 dat id bit0 forced", {57'h0, dat_id_o}, 64'h2B);
    endtask

    task automatic t_sparse();
        logic [31:0] d;
        wr(12'hEE8, 32'h0000_01FF);
        chk("R6 all sparse", dat_data_o, spread(9'h1FF, 9));
        wr(12'hEE8, 32'hFFFF_F101);
        chk("R6 bits 0 and 63", dat_data_o, 64'h8000_0000_0000_0001);
        rd(12'hEE8, d);
        chk("R6 readback", {32'h0, d}, 64'h101);
        wr(12'hEEC, 32'h0000_001F);
        chk("R7 all sparse", {32'h0, ins_data_o}, spread(9'h01F, 5));
        wr(12'hEEC, 32'h0000_0012);
        chk("R7 bits 7 and 31", {32'h0, ins_data_o}, 64'h8000_0080);
    endtask

    task automatic t_ctl();
        logic [31:0] d;
        wr(12'hEF8, 32'h0000_0503);
        chk("R8 dat ctl", {58'h0, dat_bytes_o, dat_flush_rdy_o, dat_valid_o}, {58'h0, 3'd5, 2'b11});
        wr(12'hEFC, 32'h0000_0302);
        chk("R8 ins ctl", {59'h0, ins_bytes_o, ins_flush_rdy_o, ins_valid_o}, {59'h0, 2'd3, 2'b10});
        rd(12'hEFC, d);
        chk("R8 ins readback", {32'h0, d}, 64'h302);
    endtask

    task automatic t_inputs();
        logic [31:0] d;
        @(negedge clk);
        dbg_ack_i = 1'b1; cpu_active_i = 1'b0; event_i = 4'hC;
        dat_ready_i = 1'b1; dat_flush_valid_i = 1'b0;
        ins_ready_i = 1'b0; ins_flush_valid_i = 1'b1;
        rd(12'hEE0, d);
        chk("R9 misc in", {32'h0, d}, 64'h2C);
        rd(12'hEF0, d);
        chk("R9 dat in", {32'h0, d}, 64'h1);
        rd(12'hEF4, d);
        chk("R9 ins in", {32'h0, d}, 64'h2);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 12'hEE0;
        #1 chk("R9 misc before change", {32'h0, reg_rdata}, 64'h2C);
        dbg_ack_i = 1'b0; cpu_active_i = 1'b1; event_i = 4'h3;
        #1 chk("R9 misc live same cycle", {32'h0, reg_rdata}, 64'h13);
        reg_rd = 1'b0;
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(12'hE00, d);
        chk("R11 unmapped read", {32'h0, d}, 64'h0);
        rd(12'hEDE, d);
        chk("R11 misaligned read", {32'h0, d}, 64'h0);
        wr(12'hEDE, 32'h0000_0F20);
        chk("R11 misaligned write no pin effect", {59'h0, ext_out_o, active_o}, {59'h0, 4'h5, 1'b0});
        rd(12'hEDC, d);
        chk("R11 register unchanged", {32'h0, d}, 64'h500);
    endtask

    task automatic t_rw_same();
        logic [31:0] d;
        @(negedge clk);
        reg_wr = 1'b1; reg_rd = 1'b1; reg_addr = 12'hEDC; reg_wdata = 32'h0000_0320;
        #1 chk("R12 read returns old value", {32'h0, reg_rdata}, 64'h500);
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        chk("R12 pins take new value", {59'h0, ext_out_o, active_o}, {59'h0, 4'h3, 1'b1});
        rd(12'hEDC, d);
        chk("R12 new value readback", {32'h0, d}, 64'h320);
    endtask

    task automatic t_leave();
        logic [31:0] d;
        @(negedge clk);
        reg_wr = 1'b1; reg_rd = 1'b1; reg_addr = 12'hF00; reg_wdata = 32'h0;
        #1 chk("R10 mode still on during leave", {32'h0, reg_rdata}, 64'h1);
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        chk("R10 dat data functional", dat_data_o, fn_dat_data);
        chk("R10 dat id functional", {57'h0, dat_id_o}, {57'h0, fn_dat_id});
        chk("R10 ins ctl functional", {59'h0, ins_bytes_o, ins_flush_rdy_o, ins_valid_o},
            {59'h0, fn_ins_bytes, fn_ins_flush_rdy, fn_ins_valid});
        wr(12'hEDC, 32'h0000_0C00);
        rd(12'hEDC, d);
        chk("R3 read zero after leave", {32'h0, d}, 64'h0);
        wr(12'hF00, 32'h1);
        rd(12'hEDC, d);
        chk("R10 value kept across leave", {32'h0, d}, 64'h320);
        chk("R10 ins data restored", {32'h0, ins_data_o}, 64'h8000_0080);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off_access();
        t_enter();
        t_misc();
        t_id();
        t_sparse();
        t_ctl();
        t_inputs();
        t_unmapped();
        t_rw_same();
        t_leave();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule